// File: doc/BRIEF.md
# Infrared Pulse Transmitter with Carrier Modulation

The block turns a queue of pulse descriptors into a waveform on one infrared output pin. Software pushes words into a small internal queue. Each word holds a logic level (mark or space) and a length counted in ticks of a programmable clock divider. A pulse engine takes words from the queue in order and holds each level for the requested number of ticks. Consecutive words play back to back, with no gap between them.

Marks can be sent as bursts of a generated carrier. One carrier period is sixteen divider ticks, and the high part of each period is set by a 4-bit duty field. A polarity control swaps which level carries the bursts. When modulation is off, the pin shows the plain level.

A service-request flag tells the host when to refill the queue. It can watch either for a queue at half depth or below, or for a queue that holds anything at all. This flag, masked by an interrupt enable, drives the interrupt line. A busy flag shows that a pulse is still being sent.

Top module: `ir_pulse_tx`

## Requirements
- R1: A queue word is {level, duration} with level in bit 16 and a 16-bit duration in bits 15:0. The pulse lasts duration × (cfg_div+1) clock cycles, and a duration of 0 plays as 1 tick. Each word starts the cycle after it is taken from the queue, or directly after the previous pulse's final tick with no idle cycle between them.
- R2: While a pulse is playing, the divider produces one tick every cfg_div+1 clock cycles. It is held at its start value while no pulse is playing.
- R3: The carrier phase counts divider ticks modulo 16. It starts at 0 when a pulse stream begins and runs on across back-to-back pulses. The carrier is high while phase ≤ cfg_duty, so the high time is (cfg_duty+1)/16 of the period.
- R4: With cfg_mod_en=1, ir_out equals (level XOR cfg_pol) AND carrier. So with cfg_pol=0 marks carry bursts, and with cfg_pol=1 spaces carry bursts. With cfg_mod_en=0, ir_out equals the raw level whatever cfg_pol is.
- R5: While no pulse is playing, busy is 0 and ir_out is 0. While a pulse is playing, busy is 1.
- R6: The queue holds 8 words, and a write to a full queue is dropped. While cfg_fifo_en is 0, the queue is emptied, writes are dropped and no word is taken.
- R7: With cfg_fifo_en=1, svc_req is (queue count ≤ 4) when cfg_wm_sel=0, and (count ≠ 0) when cfg_wm_sel=1. svc_req is 0 while cfg_fifo_en is 0.
- R8: irq is 1 exactly when svc_req and irq_en are both 1.
- R9: Dropping cfg_tx_en ends the current pulse at once and resets the divider, carrier phase and pulse counter. The cut-short word is discarded, and queued words stay in the queue. After re-enable, the next word starts from phase 0.
- R10: A write and a take from the queue in the same cycle are both honoured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_tx_en | input | 1 | Transmitter enable |
| cfg_fifo_en | input | 1 | Queue enable; low empties the queue |
| cfg_mod_en | input | 1 | Carrier modulation enable |
| cfg_pol | input | 1 | Carrier polarity swap |
| cfg_wm_sel | input | 1 | Service watermark: 0 half or less, 1 not empty |
| cfg_div | input | 16 | Divider: tick period minus one, in clocks |
| cfg_duty | input | 4 | Carrier high time minus one, in sixteenths |
| irq_en | input | 1 | Service-request interrupt enable |
| wr_valid | input | 1 | Queue write strobe |
| wr_level | input | 1 | Level of written word (1 = mark) |
| wr_dur | input | 16 | Duration of written word in ticks |
| ir_out | output | 1 | Infrared output pin |
| busy | output | 1 | A pulse is being sent |
| svc_req | output | 1 | Queue service request |
| irq | output | 1 | Interrupt |

## Verification
A host write can arrive on the same edge that the pulse engine takes the next word, at the final tick of the previous pulse. The bench provokes this by timing a write to land exactly on the edge where a two-word queue hands over its last entry. It then compares every cycle of the following waveform against a model built from the word list, so a lost write or a gap in playback shows up as a mismatch. The abort path is also hit while a pulse is mid-stream. The bench checks that the queued word plays next from phase 0.

// File: rtl/irtx_pkg.sv
package irtx_pkg;
   localparam int unsigned CARRIER_TICKS = 16;
   localparam int unsigned PHASE_W       = 4;

   function automatic logic carrier_high(input logic [PHASE_W-1:0] phase,
                                         input logic [PHASE_W-1:0] duty);
      return phase <= duty;
   endfunction
endpackage

// File: rtl/irtx_fifo.sv
module irtx_fifo #(
   parameter int unsigned WIDTH = 17,
   parameter int unsigned DEPTH = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         flush,
   input  logic                         wr,
   input  logic [WIDTH-1:0]             wdata,
   input  logic                         rd,
   output logic [WIDTH-1:0]             rdata,
   output logic [$clog2(DEPTH+1)-1:0]   count,
   output logic                         empty,
   output logic                         full
);
   localparam int unsigned PTR_W = $clog2(DEPTH);
   localparam int unsigned CNT_W = $clog2(DEPTH+1);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("irtx_fifo: DEPTH must be a power of two of at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PTR_W-1:0] wp, rp;
   logic             wr_ok, rd_ok;

   assign empty = (count == '0);
   assign full  = (count == CNT_W'(DEPTH));
   assign wr_ok = wr && !full && !flush;
   assign rd_ok = rd && !empty && !flush;
   assign rdata = mem[rp];

   always_ff @(posedge clk) begin
      if (wr_ok) mem[wp] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp <= '0; rp <= '0; count <= '0;
      end else if (flush) begin
         wp <= '0; rp <= '0; count <= '0;
      end else begin
         if (wr_ok) wp <= wp + 1'b1;
         if (rd_ok) rp <= rp + 1'b1;
         case ({wr_ok, rd_ok})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   // R6
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH));
   // R6
   full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full && wr && !rd && !flush) |=> (count == CNT_W'(DEPTH)));
endmodule

// File: rtl/irtx_divider.sv
module irtx_divider #(
   parameter int unsigned DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   generate
      if (DIV_W < 1) begin : g_bad_w
         $error("irtx_divider: DIV_W must be positive");
      end
   endgenerate

   logic [DIV_W-1:0] cnt;

   assign tick = run && (cnt == div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cnt <= '0;
      else if (!run)      cnt <= '0;
      else if (cnt == div) cnt <= '0;
      else                cnt <= cnt + 1'b1;
   end

   // R2
   tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && div != '0 && $stable(div)) |=> !tick);
endmodule

// File: rtl/irtx_carrier.sv
module irtx_carrier
   import irtx_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run,
   input  logic               tick,
   input  logic [PHASE_W-1:0] duty,
   output logic               carrier_hi
);
   generate
      if ((1 << PHASE_W) != CARRIER_TICKS) begin : g_bad_phase
         $error("irtx_carrier: phase width does not match carrier length");
      end
   endgenerate

   logic [PHASE_W-1:0] phase;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     phase <= '0;
      else if (!run)  phase <= '0;
      else if (tick)  phase <= phase + 1'b1;
   end

   assign carrier_hi = carrier_high(phase, duty);

   // R3
   full_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (duty == '1) |-> carrier_hi);
endmodule

// File: rtl/ir_pulse_tx.sv
module ir_pulse_tx
   import irtx_pkg::*;
#(
   parameter int unsigned DUR_W = 16,
   parameter int unsigned DIV_W = 16,
   parameter int unsigned DEPTH = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_tx_en,
   input  logic               cfg_fifo_en,
   input  logic               cfg_mod_en,
   input  logic               cfg_pol,
   input  logic               cfg_wm_sel,
   input  logic [DIV_W-1:0]   cfg_div,
   input  logic [PHASE_W-1:0] cfg_duty,
   input  logic               irq_en,
   input  logic               wr_valid,
   input  logic               wr_level,
   input  logic [DUR_W-1:0]   wr_dur,
   output logic               ir_out,
   output logic               busy,
   output logic               svc_req,
   output logic               irq
);
   localparam int unsigned WORD_W = DUR_W + 1;
   localparam int unsigned CNT_W  = $clog2(DEPTH+1);
   localparam int unsigned HALF   = DEPTH / 2;

   generate
      if (DUR_W < 2) begin : g_bad_dur
         $error("ir_pulse_tx: DUR_W too small");
      end
   endgenerate

   logic [WORD_W-1:0] head;
   logic [CNT_W-1:0]  q_count;
   logic              q_empty, q_full;
   logic              tick, carrier_hi;
   logic              active, level_q;
   logic [DUR_W-1:0]  remain;
   logic              last_tick, take;

   irtx_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .flush(!cfg_fifo_en),
      .wr(wr_valid), .wdata({wr_level, wr_dur}),
      .rd(take), .rdata(head), .count(q_count),
      .empty(q_empty), .full(q_full)
   );

   irtx_divider #(.DIV_W(DIV_W)) u_div (
      .clk(clk), .rst_n(rst_n), .run(active), .div(cfg_div), .tick(tick)
   );

   irtx_carrier u_car (
      .clk(clk), .rst_n(rst_n), .run(active), .tick(tick),
      .duty(cfg_duty), .carrier_hi(carrier_hi)
   );

   assign last_tick = active && tick && (remain == DUR_W'(1));
   assign take      = cfg_tx_en && cfg_fifo_en && !q_empty && (!active || last_tick);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0; level_q <= 1'b0; remain <= '0;
      end else if (!cfg_tx_en) begin
         active <= 1'b0; level_q <= 1'b0; remain <= '0;
      end else if (take) begin
         active  <= 1'b1;
         level_q <= head[DUR_W];
         remain  <= (head[DUR_W-1:0] == '0) ? DUR_W'(1) : head[DUR_W-1:0];
      end else if (active && tick) begin
         if (remain == DUR_W'(1)) active <= 1'b0;
         else                     remain <= remain - 1'b1;
      end
   end

   assign busy    = active;
   assign ir_out  = active && (cfg_mod_en ? ((level_q ^ cfg_pol) && carrier_hi) : level_q);
   assign svc_req = cfg_fifo_en && (cfg_wm_sel ? !q_empty : (q_count <= CNT_W'(HALF)));
   assign irq     = svc_req && irq_en;

   // R5
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !ir_out);
   // R9
   abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_tx_en |=> !busy);
   // R1
   take_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> busy);
endmodule

// File: tb/tb_ir_pulse_tx.sv
module tb_ir_pulse_tx;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_tx_en = 1'b0, cfg_fifo_en = 1'b0, cfg_mod_en = 1'b0;
   logic        cfg_pol = 1'b0, cfg_wm_sel = 1'b0, irq_en = 1'b0;
   logic [15:0] cfg_div = '0;
   logic [3:0]  cfg_duty = '0;
   logic        wr_valid = 1'b0, wr_level = 1'b0;
   logic [15:0] wr_dur = '0;
   logic        ir_out, busy, svc_req, irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   int lv [16];
   int du [16];
   int nw;

   always #2 clk = ~clk;

   ir_pulse_tx dut (
      .clk(clk), .rst_n(rst_n), .cfg_tx_en(cfg_tx_en), .cfg_fifo_en(cfg_fifo_en),
      .cfg_mod_en(cfg_mod_en), .cfg_pol(cfg_pol), .cfg_wm_sel(cfg_wm_sel),
      .cfg_div(cfg_div), .cfg_duty(cfg_duty), .irq_en(irq_en),
      .wr_valid(wr_valid), .wr_level(wr_level), .wr_dur(wr_dur),
      .ir_out(ir_out), .busy(busy), .svc_req(svc_req), .irq(irq)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic push(input int l, input int d);
      wr_valid = 1'b1; wr_level = l[0]; wr_dur = d[15:0];
      @(negedge clk);
      wr_valid = 1'b0;
   endtask

   // Expected {busy, ir_out} k cycles after the first word is taken.
   function automatic int expect_at(input int k, input int dv, input int dty,
                                    input int pl, input int md);
      int t, cum, d;
      t = k / (dv + 1);
      cum = 0;
      for (int i = 0; i < nw; i++) begin
         d = (du[i] == 0) ? 1 : du[i];
         if (t < cum + d) begin
            int ph, o;
            ph = t % 16;
            if (md != 0) o = ((lv[i] ^ pl) != 0 && ph <= dty) ? 1 : 0;
            else         o = lv[i];
            return 2 + o;
         end
         cum += d;
      end
      return 0;
   endfunction

   // FIFO must already hold the words; enables tx and compares every cycle.
   task automatic play(input int dv, input int dty, input int pl, input int md,
                       input int inj_k, input string req);
      int tot, e;
      tot = 0;
      for (int i = 0; i < nw; i++) tot += (du[i] == 0) ? 1 : du[i];
      cfg_div = dv[15:0]; cfg_duty = dty[3:0]; cfg_pol = pl[0]; cfg_mod_en = md[0];
      cfg_tx_en = 1'b1;
      for (int k = 0; k < tot * (dv + 1) + 3; k++) begin
         @(negedge clk);
         wr_valid = 1'b0;
         e = expect_at(k, dv, dty, pl, md);
         chk({req, " busy"}, int'(busy), e / 2);
         chk({req, " ir_out"}, int'(ir_out), e % 2);
         if (k == inj_k) begin
            wr_valid = 1'b1; wr_level = lv[nw-1][0]; wr_dur = du[nw-1][15:0];
         end
      end
      cfg_tx_en = 1'b0;
      @(negedge clk);
   endtask

   task automatic load_std;
      lv[0] = 1; du[0] = 20;
      lv[1] = 0; du[1] = 3;
      lv[2] = 1; du[2] = 0;
      lv[3] = 1; du[3] = 5;
      lv[4] = 0; du[4] = 2;
      nw = 5;
      for (int i = 0; i < nw; i++) push(lv[i], du[i]);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R5 reset state; R7 svc off with queue disabled; R8
      chk("R5 reset busy", int'(busy), 0);
      chk("R5 reset ir_out", int'(ir_out), 0);
      chk("R7 svc disabled", int'(svc_req), 0);
      chk("R8 irq reset", int'(irq), 0);

      // R6 R7 R8: fill past full, sweep watermark and enable each step
      cfg_fifo_en = 1'b1;
      @(negedge clk);
      for (int n = 0; n <= 10; n++) begin
         int c;
         c = (n > 8) ? 8 : n;
         for (int w = 0; w < 2; w++) begin
            for (int ie = 0; ie < 2; ie++) begin
               int es;
               cfg_wm_sel = w[0]; irq_en = ie[0];
               #1;
               es = (w == 0) ? ((c <= 4) ? 1 : 0) : ((c != 0) ? 1 : 0);
               chk("R7 svc_req", int'(svc_req), es);
               chk("R8 irq", int'(irq), es & ie);
            end
         end
         if (n < 10) begin
            lv[n] = n % 2; du[n] = n + 1;
            push(lv[n], du[n]);
         end
      end
      irq_en = 1'b0;
      // R6: only 8 words play; R4: raw level with polarity set, no modulation
      nw = 8;
      play(0, 0, 1, 0, -1, "R6 R4 full-drop raw");

      // R1 R2 R3 R4 R5: duty and polarity sweep, modulation on and off
      for (int dty = 0; dty < 16; dty++)
         for (int pl = 0; pl < 2; pl++)
            for (int md = 0; md < 2; md++) begin
               load_std();
               play(0, dty, pl, md, -1, "R3 R4 sweep");
            end
      for (int dv = 1; dv < 4; dv++) begin
         load_std();
         play(dv, 7, 0, 1, -1, "R2 R1 divider");
      end

      // R9: abort mid-pulse, queued word kept and starts fresh
      push(1, 50);
      push(1, 4);
      cfg_mod_en = 1'b1; cfg_pol = 1'b0; cfg_duty = 4'd1; cfg_div = '0;
      cfg_tx_en = 1'b1;
      for (int k = 0; k < 10; k++) begin
         @(negedge clk);
         chk("R9 busy before abort", int'(busy), 1);
      end
      cfg_tx_en = 1'b0;
      @(negedge clk);
      chk("R9 abort busy", int'(busy), 0);
      chk("R9 abort ir_out", int'(ir_out), 0);
      lv[0] = 1; du[0] = 4; nw = 1;
      play(0, 1, 0, 1, -1, "R9 resume");

      // R10: write lands on the edge that takes the last queued word
      push(1, 3);
      push(0, 2);
      lv[0] = 1; du[0] = 3; lv[1] = 0; du[1] = 2; lv[2] = 1; du[2] = 2; nw = 3;
      play(0, 15, 0, 0, 2, "R10 write+take");

      // R6: writes while queue disabled are dropped
      cfg_fifo_en = 1'b0;
      push(1, 5);
      cfg_fifo_en = 1'b1;
      cfg_tx_en = 1'b1;
      repeat (3) begin
         @(negedge clk);
         chk("R6 disabled write dropped", int'(busy), 0);
      end
      cfg_wm_sel = 1'b1;
      #1;
      chk("R6 R7 queue empty", int'(svc_req), 0);
      cfg_tx_en = 1'b0;

      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule